// File: doc/BRIEF.md
# Two-Operand Register ALU with Condition Flags

This block is the data-processing unit for the two-register instruction group of a compact 32-bit instruction set. Each operation takes a 4-bit operation code, a destination operand, a source operand and the current condition flags. It produces the result, a write strobe for the destination register and the next flag set. The decoder and the register file stay outside the block. The caller supplies the operand values and commits the result and flags when the block presents them.

The result is computed in one combinational pass. One output register stage then captures it when `valid_i` is high. The captured values appear on the outputs one clock later, and `valid_o` goes high for that one cycle. Flags are packed as `{N, Z, C, V}`, with N in bit 3 and V in bit 0.

Register-specified shifts take their amount from the low byte of the source operand. For amounts of 32 or more, the result and carry match what shifting one bit at a time would give.

Top module: `dp_alu`

## Requirements
- R1: Operation codes are 0 AND, 1 EOR, 2 LSL, 3 LSR, 4 ASR, 5 ADC, 6 SBC, 7 ROR, 8 TST, 9 NEG, 10 CMP, 11 CMN, 12 ORR, 13 MUL, 14 BIC (dst AND NOT src), 15 MVN (NOT src). `wr_en_o` is 0 for TST, CMP and CMN and 1 for every other code. `result_o` always carries the computed value. For TST it is dst AND src, for CMP it is dst minus src, and for CMN it is dst plus src.
- R2: AND, EOR, ORR, BIC, MVN and TST set N to result bit 31 and Z to (result == 0). They leave C and V at their input values. For every operation, Z on the outputs equals (result_o == 0).
- R3: ADC returns dst + src + C_in. SBC returns dst - src - (1 - C_in). CMP computes dst - src and CMN computes dst + src. For all of these, C is the carry out of bit 31, so C = 1 means no borrow on a subtraction. V is the signed overflow, meaning bit 31 of ~(a^b)&(a^r), where a and b are the adder inputs after inversion.
- R4: NEG returns 0 - src and writes the destination. Its flags follow the subtract rule, so src = 0 gives C = 1, and src = 0x80000000 gives V = 1.
- R5: Shifts use only src[7:0] as the amount. An amount of 0 returns dst unchanged and leaves C unchanged, whatever the upper source bits hold.
- R6: For LSL and LSR by 1 to 31, C is the last bit shifted out. By exactly 32, the result is 0 and C is dst[0] for LSL or dst[31] for LSR. By more than 32, the result is 0 and C is 0.
- R7: ASR by 1 to 31 shifts in copies of the sign bit, and C is the last bit shifted out. By 32 or more, every result bit equals dst[31], and so does C.
- R8: ROR rotates right by amount mod 32, and C equals result bit 31. A nonzero amount that is a multiple of 32 returns dst unchanged, with C = dst[31].
- R9: MUL returns the low 32 bits of dst * src, clears C and leaves V unchanged.
- R10: Outputs change only on the clock edge after `valid_i` is high. `valid_o` is high for exactly that following cycle. While `valid_i` is low, the result, write strobe and flags hold. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present on the inputs this cycle |
| op_i | input | 4 | Operation code |
| dst_i | input | 32 | Destination operand (first operand) |
| src_i | input | 32 | Source operand; low byte is the shift amount |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| valid_o | output | 1 | Registered outputs updated this cycle |
| result_o | output | 32 | Computed value |
| wr_en_o | output | 1 | Destination register should be written |
| flags_o | output | 4 | Next flags {N,Z,C,V} |

## Verification
The block has a single register stage, so any fault in the operand muxing, the shifter range handling or the carry logic shows up one cycle after the operation is issued, as a wrong result or flag bit. A fault in the hold path instead shows up as outputs moving in an idle cycle. The risky states are the shift amounts 0, 31, 32, 33 and 255, and amounts where the upper source bits are set but the low byte is 0. A carry that is stale, dropped or taken from the wrong edge shows only in C, so every check compares all four flags together with the result and the write strobe.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'd0, OP_EOR = 4'd1, OP_LSL = 4'd2, OP_LSR = 4'd3,
    OP_ASR = 4'd4, OP_ADC = 4'd5, OP_SBC = 4'd6, OP_ROR = 4'd7,
    OP_TST = 4'd8, OP_NEG = 4'd9, OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MUL = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {SH_LSL, SH_LSR, SH_ASR, SH_ROR} shift_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;
endpackage

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND, OP_TST: res_o = a_i & b_i;
      OP_EOR:         res_o = a_i ^ b_i;
      OP_ORR:         res_o = a_i | b_i;
      OP_BIC:         res_o = a_i & ~b_i;
      OP_MVN:         res_o = ~b_i;
      default:        res_o = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu_addsub.sv
module dp_alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_o,
  output logic             v_o
);
  logic [WIDTH-1:0] ovf_vec, cry_vec;

  assign sum_o   = a_i + b_i + {{(WIDTH-1){1'b0}}, cin_i};
  // per-bit overflow term; msb gives V, and xor with operands recovers carry out
  assign ovf_vec = ~(a_i ^ b_i) & (a_i ^ sum_o);
  assign cry_vec = ovf_vec ^ a_i ^ b_i ^ sum_o;
  assign v_o     = ovf_vec[WIDTH-1];
  assign c_o     = cry_vec[WIDTH-1];
endmodule

// File: rtl/dp_alu_shift.sv
module dp_alu_shift
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8
) (
  input  shift_kind_e      kind_i,
  input  logic [WIDTH-1:0] val_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] res_o,
  output logic             c_o
);
  localparam int SH_W = $clog2(WIDTH);

  logic [SH_W-1:0] sh;
  logic            amt_zero, amt_full, amt_over;
  logic [WIDTH:0]  lsl_w, lsr_w, asr_w;
  logic [WIDTH-1:0] ror_w;

  assign sh       = amt_i[SH_W-1:0];
  assign amt_zero = (amt_i == '0);
  assign amt_full = (amt_i == AMT_W'(WIDTH));
  assign amt_over = |amt_i[AMT_W-1:SH_W];   // amount >= WIDTH

  // one extra bit catches the last bit shifted out
  assign lsl_w = {1'b0, val_i} << sh;
  assign lsr_w = {val_i, 1'b0} >> sh;
  assign asr_w = $signed({val_i, 1'b0}) >>> sh;
  assign ror_w = (val_i >> sh) | (val_i << ((SH_W+1)'(WIDTH) - {1'b0, sh}));

  always_comb begin
    res_o = val_i;
    c_o   = c_i;
    if (!amt_zero) begin
      unique case (kind_i)
        SH_LSL: begin
          if (amt_over) begin
            res_o = '0;
            c_o   = amt_full ? val_i[0] : 1'b0;
          end else begin
            res_o = lsl_w[WIDTH-1:0];
            c_o   = lsl_w[WIDTH];
          end
        end
        SH_LSR: begin
          if (amt_over) begin
            res_o = '0;
            c_o   = amt_full ? val_i[WIDTH-1] : 1'b0;
          end else begin
            res_o = lsr_w[WIDTH:1];
            c_o   = lsr_w[0];
          end
        end
        SH_ASR: begin
          if (amt_over) begin
            res_o = {WIDTH{val_i[WIDTH-1]}};
            c_o   = val_i[WIDTH-1];
          end else begin
            res_o = asr_w[WIDTH:1];
            c_o   = asr_w[0];
          end
        end
        default: begin
          res_o = ror_w;
          c_o   = ror_w[WIDTH-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] dst_i,
  input  logic [WIDTH-1:0] src_i,
  input  logic [3:0]       flags_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] result_o,
  output logic             wr_en_o,
  output logic [3:0]       flags_o
);
  alu_op_e     op;
  alu_flags_t  f_in, f_nxt;
  logic [WIDTH-1:0] logic_res, sh_res, as_sum, as_a, as_b, mul_lo, res_nxt;
  logic        sh_c, as_c, as_v, as_cin, wr_nxt;
  shift_kind_e sh_kind;

  assign op   = alu_op_e'(op_i);
  assign f_in = alu_flags_t'(flags_i);

  dp_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .op_i (op), .a_i (dst_i), .b_i (src_i), .res_o (logic_res)
  );

  always_comb begin
    unique case (op)
      OP_LSR:  sh_kind = SH_LSR;
      OP_ASR:  sh_kind = SH_ASR;
      OP_ROR:  sh_kind = SH_ROR;
      default: sh_kind = SH_LSL;
    endcase
  end

  dp_alu_shift #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_shift (
    .kind_i (sh_kind), .val_i (dst_i), .amt_i (src_i[AMT_W-1:0]),
    .c_i (f_in.c), .res_o (sh_res), .c_o (sh_c)
  );

  // subtract forms feed the inverted source with a carry in
  always_comb begin
    as_a   = dst_i;
    as_b   = src_i;
    as_cin = 1'b0;
    unique case (op)
      OP_ADC: as_cin = f_in.c;
      OP_SBC: begin as_b = ~src_i; as_cin = f_in.c; end
      OP_CMP: begin as_b = ~src_i; as_cin = 1'b1;   end
      OP_NEG: begin as_a = '0; as_b = ~src_i; as_cin = 1'b1; end
      default: ;
    endcase
  end

  dp_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i (as_a), .b_i (as_b), .cin_i (as_cin),
    .sum_o (as_sum), .c_o (as_c), .v_o (as_v)
  );

  assign mul_lo = dst_i * src_i;

  always_comb begin
    f_nxt   = f_in;
    res_nxt = logic_res;
    wr_nxt  = 1'b1;
    unique case (op)
      OP_AND, OP_EOR, OP_ORR, OP_BIC, OP_MVN: res_nxt = logic_res;
      OP_TST: wr_nxt = 1'b0;
      OP_LSL, OP_LSR, OP_ASR, OP_ROR: begin
        res_nxt = sh_res;
        f_nxt.c = sh_c;
      end
      OP_ADC, OP_SBC, OP_NEG, OP_CMP, OP_CMN: begin
        res_nxt = as_sum;
        f_nxt.c = as_c;
        f_nxt.v = as_v;
        wr_nxt  = !(op inside {OP_CMP, OP_CMN});
      end
      OP_MUL: begin
        res_nxt = mul_lo;
        f_nxt.c = 1'b0;
      end
      default: ;
    endcase
    f_nxt.n = res_nxt[WIDTH-1];
    f_nxt.z = (res_nxt == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      wr_en_o  <= 1'b0;
      flags_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_nxt;
        wr_en_o  <= wr_nxt;
        flags_o  <= f_nxt;
      end
    end
  end

  AST_NO_WRITE_ON_COMPARE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i inside {4'd8, 4'd10, 4'd11}) |=> !wr_en_o);  // R1
  AST_LOGIC_KEEPS_CV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i inside {4'd0, 4'd1, 4'd8, 4'd12, 4'd14, 4'd15})
    |=> flags_o[1:0] == $past(flags_i[1:0]));  // R2
  AST_Z_TRACKS_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> flags_o[2] == (result_o == '0));  // R2
  AST_ZERO_SHIFT_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i inside {4'd2, 4'd3, 4'd4, 4'd7}) && (src_i[AMT_W-1:0] == '0)
    |=> flags_o[1] == $past(flags_i[1]) && result_o == $past(dst_i));  // R5
  AST_MUL_CLEARS_C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'd13 |=> !flags_o[1] && flags_o[0] == $past(flags_i[0]));  // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(result_o) && $stable(flags_o) && $stable(wr_en_o));  // R10
endmodule

// File: tb/sim_dp_alu.sv
module sim_dp_alu;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] dst_i = '0, src_i = '0;
  logic [3:0]  flags_i = '0;
  logic        valid_o, wr_en_o;
  logic [31:0] result_o;
  logic [3:0]  flags_o;
  int errors = 0;
  int checks = 0;

  localparam logic [3:0] AND_ = 0, EOR_ = 1, LSL_ = 2, LSR_ = 3, ASR_ = 4, ADC_ = 5,
    SBC_ = 6, ROR_ = 7, TST_ = 8, NEG_ = 9, CMP_ = 10, CMN_ = 11, ORR_ = 12,
    MUL_ = 13, BIC_ = 14, MVN_ = 15;

  always #4 clk = ~clk;

  dp_alu u0 (
    .clk_i (clk), .rst_ni (rst_ni), .valid_i (valid_i), .op_i (op_i),
    .dst_i (dst_i), .src_i (src_i), .flags_i (flags_i), .valid_o (valid_o),
    .result_o (result_o), .wr_en_o (wr_en_o), .flags_o (flags_o)
  );

  // {result, wr, N, Z, C, V}
  function automatic logic [36:0] ref_model(logic [3:0] op, logic [31:0] d, logic [31:0] s,
                                            logic [3:0] f);
    logic n, z, c, v, wr;
    logic [31:0] r;
    logic [32:0] w;
    int amt;
    {n, z, c, v} = f;
    wr  = 1'b1;
    r   = '0;
    amt = int'(s[7:0]);
    case (op)
      AND_: r = d & s;
      EOR_: r = d ^ s;
      ORR_: r = d | s;
      BIC_: r = d & ~s;
      MVN_: r = ~s;
      TST_: begin r = d & s; wr = 1'b0; end
      LSL_: begin r = d; for (int i = 0; i < amt; i++) begin c = r[31]; r = r << 1; end end
      LSR_: begin r = d; for (int i = 0; i < amt; i++) begin c = r[0]; r = r >> 1; end end
      ASR_: begin r = d; for (int i = 0; i < amt; i++) begin c = r[0]; r = {r[31], r[31:1]}; end end
      ROR_: begin r = d; for (int i = 0; i < amt; i++) begin c = r[0]; r = {r[0], r[31:1]}; end end
      ADC_, CMN_: begin
        w = {1'b0, d} + {1'b0, s} + ((op == ADC_) ? {32'd0, c} : 33'd0);
        r = w[31:0]; c = w[32]; v = (d[31] == s[31]) && (r[31] != d[31]);
        wr = (op == ADC_);
      end
      SBC_, CMP_: begin
        w = {1'b0, d} - {1'b0, s} - ((op == SBC_) ? {32'd0, !c} : 33'd0);
        r = w[31:0]; c = !w[32]; v = (d[31] != s[31]) && (r[31] != d[31]);
        wr = (op == SBC_);
      end
      NEG_: begin
        w = 33'd0 - {1'b0, s};
        r = w[31:0]; c = !w[32]; v = s[31] && r[31];
      end
      MUL_: begin r = d * s; c = 1'b0; end
      default: ;
    endcase
    n = r[31];
    z = (r == 0);
    return {r, wr, n, z, c, v};
  endfunction

  task automatic check(input string tag, input logic [37:0] act, input logic [37:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got valid/res/wr/nzcv=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [3:0] op, input logic [31:0] d,
                        input logic [31:0] s, input logic [3:0] f);
    logic [36:0] exp;
    exp = ref_model(op, d, s, f);
    @(negedge clk);
    op_i = op; dst_i = d; src_i = s; flags_i = f; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check(tag, {valid_o, result_o, wr_en_o, flags_o}, {1'b1, exp});
  endtask

  task automatic t_reset;
    check("R10 reset", {valid_o, result_o, wr_en_o, flags_o}, 38'd0);
  endtask

  task automatic t_logic;
    run_op("R2 AND", AND_, 32'hF0F0_1234, 32'h0FF0_FF00, 4'b0011);
    run_op("R2 EOR", EOR_, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 4'b0010);
    run_op("R2 ORR", ORR_, 32'h8000_0000, 32'h0000_0001, 4'b0001);
    run_op("R2 BIC", BIC_, 32'hFFFF_FFFF, 32'h0000_FFFF, 4'b0110);
    run_op("R2 MVN", MVN_, 32'h1234_5678, 32'hFFFF_FFFF, 4'b1011);
    run_op("R1 TST no write", TST_, 32'h0000_00F0, 32'h0000_000F, 4'b0011);
    check("R1 TST strobe low", {31'd0, wr_en_o}, 32'd0);
  endtask

  task automatic t_addsub;
    run_op("R3 ADC cin0", ADC_, 32'h7FFF_FFFF, 32'h0000_0001, 4'b0000);
    run_op("R3 ADC cin1 wrap", ADC_, 32'hFFFF_FFFF, 32'h0000_0000, 4'b0010);
    run_op("R3 SBC cin1", SBC_, 32'h0000_0005, 32'h0000_0003, 4'b0010);
    run_op("R3 SBC cin0", SBC_, 32'h0000_0005, 32'h0000_0005, 4'b0000);
    run_op("R3 SBC overflow", SBC_, 32'h8000_0000, 32'h0000_0001, 4'b0010);
    run_op("R3 CMP equal", CMP_, 32'h1234_0000, 32'h1234_0000, 4'b0000);
    check("R1 CMP strobe low", {31'd0, wr_en_o}, 32'd0);
    run_op("R3 CMP borrow", CMP_, 32'h0000_0001, 32'h0000_0002, 4'b0010);
    run_op("R3 CMN carry", CMN_, 32'hFFFF_FFFF, 32'h0000_0001, 4'b0000);
  endtask

  task automatic t_neg;
    run_op("R4 NEG zero", NEG_, 32'hDEAD_BEEF, 32'h0000_0000, 4'b0000);
    run_op("R4 NEG one", NEG_, 32'h0, 32'h0000_0001, 4'b0010);
    run_op("R4 NEG min", NEG_, 32'h0, 32'h8000_0000, 4'b0000);
    check("R4 NEG min V", {28'd0, flags_o}, {28'd0, 4'b1001});
  endtask

  task automatic t_shift_zero;
    run_op("R5 LSL amt0 upper bits", LSL_, 32'h8000_0001, 32'hFFFF_FF00, 4'b0010);
    run_op("R5 LSR amt0", LSR_, 32'h8000_0001, 32'h0000_0100, 4'b0000);
    run_op("R5 ASR amt0", ASR_, 32'h8000_0001, 32'h1234_5600, 4'b0010);
    run_op("R5 ROR amt0", ROR_, 32'h0000_0003, 32'h0000_0000, 4'b0000);
    run_op("R5 LSL low byte 1", LSL_, 32'h8000_0001, 32'hABCD_EF01, 4'b0000);
  endtask

  task automatic t_lsl_lsr;
    int amts[5] = '{1, 31, 32, 33, 255};
    foreach (amts[i]) begin
      run_op("R6 LSL", LSL_, 32'h8000_0001, 32'(amts[i]), 4'b0010);
      run_op("R6 LSR", LSR_, 32'h8000_0001, 32'(amts[i]), 4'b0010);
    end
    run_op("R6 LSL by32 c", LSL_, 32'h0000_0001, 32'd32, 4'b0000);
    check("R6 LSL by32 C=bit0", {result_o, flags_o}, {32'd0, 4'b0110});
  endtask

  task automatic t_asr;
    run_op("R7 ASR 31 neg", ASR_, 32'h8000_0000, 32'd31, 4'b0000);
    run_op("R7 ASR 32 neg", ASR_, 32'h8000_0000, 32'd32, 4'b0000);
    check("R7 ASR 32 fill", {result_o, flags_o}, {32'hFFFF_FFFF, 4'b1010});
    run_op("R7 ASR 40 pos", ASR_, 32'h7FFF_FFFF, 32'd40, 4'b0010);
    run_op("R7 ASR 255 neg", ASR_, 32'hC000_0000, 32'd255, 4'b0000);
    run_op("R7 ASR 4", ASR_, 32'hF000_0008, 32'd4, 4'b0000);
  endtask

  task automatic t_ror;
    run_op("R8 ROR 4", ROR_, 32'h1234_5678, 32'd4, 4'b0000);
    run_op("R8 ROR 32", ROR_, 32'h8000_0001, 32'd32, 4'b0000);
    check("R8 ROR 32 value", {result_o, flags_o}, {32'h8000_0001, 4'b1010});
    run_op("R8 ROR 64", ROR_, 32'h7000_0000, 32'd64, 4'b0010);
    run_op("R8 ROR 33", ROR_, 32'h0000_0001, 32'd33, 4'b0000);
    run_op("R8 ROR 255", ROR_, 32'hA5A5_0F0F, 32'd255, 4'b0000);
  endtask

  task automatic t_mul;
    run_op("R9 MUL small", MUL_, 32'd1000, 32'd3000, 4'b0011);
    run_op("R9 MUL wrap", MUL_, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b0010);
    run_op("R9 MUL zero", MUL_, 32'h0001_0000, 32'h0001_0000, 4'b0011);
  endtask

  task automatic t_hold;
    logic [37:0] snap;
    run_op("R10 load", EOR_, 32'h1111_0000, 32'h0000_2222, 4'b0000);
    snap = {1'b0, result_o, wr_en_o, flags_o};
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      op_i = 4'(i + 8); dst_i = 32'hFFFF_0000 + 32'(i); src_i = 32'h5; flags_i = 4'hF;
    end
    @(negedge clk);
    check("R10 hold while idle", {valid_o, result_o, wr_en_o, flags_o}, snap);
  endtask

  task automatic t_random;
    logic [31:0] d, s;
    logic [3:0] op, f;
    for (int i = 0; i < 300; i++) begin
      d = $urandom; s = $urandom; op = 4'($urandom); f = 4'($urandom);
      if (i % 3 == 0) s = {s[31:8], 8'(i % 70)};
      run_op("R1 random op", op, d, s, f);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL R10 watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_logic();
    t_addsub();
    t_neg();
    t_shift_zero();
    t_lsl_lsr();
    t_asr();
    t_ror();
    t_mul();
    t_hold();
    t_random();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule